// File: doc/BRIEF.md
# Transmit/Receive Standby Sequencer

This controller decides, one clock at a time, whether a transceiver should be transmitting or receiving. Four standby request sources feed it: a manual push switch that pulls low, and three sources that drive high when they want transmit (an antenna tuner, a host computer link and a voice-operated switch). Any one of them is enough to ask for transmit. A transmit-permit line can veto the request. The result drives a transmit-enable output and its exact complement, a receive-enable output.

A third output, keying-enable, allows the transmitter to produce RF. It does not follow transmit-enable at once. It waits until the request has been held without a break for a programmable number of milliseconds, 10 by default. Milliseconds are counted from an external tick-enable strobe, and a prescaler ratio parameter converts ticks into milliseconds. If the request is released, even briefly, the wait starts again from zero. When the transceiver is in CW mode, keying-enable also needs the keyer to be closed. The choice between semi and full break-in does not change any timing. When a session ends, keying-enable drops before transmit-enable does, so RF is never keyed while the receiver is enabled.

Top module: `trx_standby_seq`

## Requirements
- R1: A low level on `stby_sw_n` requests transmit.
- R2: A high level on `tuner_req`, `host_req` or `vox_req` requests transmit, each one acting alone.
- R3: While the synchronised `tx_permit` is low, `tx_en` and `key_en` are low, whatever requests are present.
- R4: Every asynchronous input passes through a two-flop synchroniser. `tx_en` rises on the third clock edge after a permitted request is applied. `tx_en` falls on the third clock edge after the request is removed.
- R5: `rx_en` is always the inverse of `tx_en`.
- R6: `key_en` can rise only after DELAY_MS*TICKS_PER_MS tick-enable pulses have arrived while a permitted request was held without a break. Any break in the request restarts the count from zero.
- R7: Clock edges on which `tick_in` is low do not advance the delay. With no ticks, `key_en` stays low.
- R8: When `cw_mode` is low, `cw_key_n` has no effect on `key_en`. When `cw_mode` is high, `key_en` also requires `cw_key_n` to be low.
- R9: `brk_full` (1 selects full break-in, 0 selects semi break-in) has no effect on any output or on the delay.
- R10: When the request goes away, `key_en` falls one clock edge before `tx_en` falls, and `key_en` is never high while `rx_en` is high.
- R11: A low `tx_permit` during transmit forces `tx_en` and `key_en` low on the same edge at which its synchronised value falls, and it clears the delay count.
- R12: While reset is held, `tx_en` is 0, `rx_en` is 1 and `key_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Synchronous tick-enable; TICKS_PER_MS pulses make one millisecond |
| stby_sw_n | input | 1 | Manual standby switch, active low |
| tuner_req | input | 1 | Antenna tuner standby request, active high |
| host_req | input | 1 | Host computer standby request, active high |
| vox_req | input | 1 | Voice-operated standby request, active high |
| tx_permit | input | 1 | 1 permits transmit, 0 blocks it |
| cw_mode | input | 1 | 1 selects CW operation |
| cw_key_n | input | 1 | Keyer contact, active low, used only in CW mode |
| brk_full | input | 1 | 1 full break-in, 0 semi break-in |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable, inverse of tx_en |
| key_en | output | 1 | Delayed keying enable |

## Verification
A delay counter that runs in the wrong state shows up only at `key_en`. If it is stuck or fails to clear, `key_en` rises too early or too late, and the edge is off by whole milliseconds, visible within one delay window of the next request. A transmit-state register that is stale shows up three edges after a request changes. It appears as `tx_en` and `rx_en` holding their old values, or as `key_en` still high while receive is enabled. Randomised bursts of every length around the delay threshold, with permit dropouts and missing ticks, expose an off-by-one error on the very edge where it occurs.

// File: rtl/trx_standby_pkg.sv
package trx_standby_pkg;

  // Synchronised view of the asynchronous inputs, MSB first.
  typedef struct packed {
    logic sw_n;
    logic tuner;
    logic host;
    logic vox;
    logic permit;
    logic cw;
    logic key_n;
    logic brk_full;
  } stby_in_t;

  localparam int STBY_IN_W = $bits(stby_in_t);

  // Idle/reset view: switch released, permit low, keyer open.
  localparam stby_in_t STBY_IDLE = '{sw_n: 1'b1, tuner: 1'b0, host: 1'b0,
                                     vox: 1'b0, permit: 1'b0, cw: 1'b0,
                                     key_n: 1'b1, brk_full: 1'b0};

  // Any source requesting transmit, polarities normalised.
  function automatic logic any_request(stby_in_t s);
    return (!s.sw_n) | s.tuner | s.host | s.vox;
  endfunction

  // Permitted request.
  function automatic logic tx_go(stby_in_t s);
    return s.permit & any_request(s);
  endfunction

  // Keyer gate: transparent outside CW, keyer contact inside CW.
  function automatic logic key_gate(stby_in_t s);
    return (!s.cw) | (!s.key_n);
  endfunction

endpackage

// File: rtl/trx_sync_bank.sv
module trx_sync_bank #(
  parameter int              W       = 8,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= RST_VAL;
        else        pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= RST_VAL;
        else        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/trx_key_delay.sv
module trx_key_delay #(
  parameter int TICKS_PER_MS = 4,
  parameter int DELAY_MS     = 10,
  localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1,
  localparam int CW = $clog2(DELAY_MS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic [CW-1:0] ms_cnt,
  output logic          done
);

  logic [PW-1:0] pre;
  logic          ms_step;

  assign ms_step = run & tick & (pre == PW'(TICKS_PER_MS - 1));
  assign done    = (ms_cnt == CW'(DELAY_MS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      ms_cnt <= '0;
    end else if (!run) begin
      pre    <= '0;
      ms_cnt <= '0;
    end else if (tick) begin
      pre <= ms_step ? '0 : pre + 1'b1;
      if (ms_step && !done) ms_cnt <= ms_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/trx_standby_seq.sv
module trx_standby_seq
  import trx_standby_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int TICKS_PER_MS = 4,
  parameter int DELAY_MS     = 10,
  localparam int CNT_W = $clog2(DELAY_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic stby_sw_n,
  input  logic tuner_req,
  input  logic host_req,
  input  logic vox_req,
  input  logic tx_permit,
  input  logic cw_mode,
  input  logic cw_key_n,
  input  logic brk_full,
  output logic tx_en,
  output logic rx_en,
  output logic key_en
);

  stby_in_t   raw_in;
  stby_in_t   sin;
  logic       go;
  logic       permit_s;
  logic       tx_q;
  logic       delay_done;
  logic [CNT_W-1:0] ms_cnt;
  logic       key_core;
  logic       key_semi;
  logic       key_full;

  assign raw_in = '{sw_n: stby_sw_n, tuner: tuner_req, host: host_req,
                    vox: vox_req, permit: tx_permit, cw: cw_mode,
                    key_n: cw_key_n, brk_full: brk_full};

  trx_sync_bank #(
    .W       (STBY_IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (STBY_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sin)
  );

  assign go       = tx_go(sin);
  assign permit_s = sin.permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= go;
  end

  trx_key_delay #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .DELAY_MS     (DELAY_MS)
  ) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (go),
    .tick   (tick_in),
    .ms_cnt (ms_cnt),
    .done   (delay_done)
  );

  assign tx_en = tx_q & permit_s;
  assign rx_en = ~tx_en;

  // Keying needs the live request as well, so it falls an edge ahead of tx_en.
  assign key_core = tx_en & go & delay_done & key_gate(sin);
  // Both break-in flavours share one timing path.
  assign key_semi = key_core;
  assign key_full = key_core;
  assign key_en   = sin.brk_full ? key_full : key_semi;

endmodule

// File: rtl/trx_standby_chk.sv
module trx_standby_chk #(
  parameter int DELAY_MS = 10,
  localparam int CNT_W = $clog2(DELAY_MS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             rx_en,
  input logic             key_en,
  input logic             go,
  input logic             permit_s,
  input logic             delay_done,
  input logic [CNT_W-1:0] ms_cnt
);

  // R5
  a_r5_rx_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en == !tx_en);

  // R10
  a_r10_no_key_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
    key_en |-> (tx_en && !rx_en));

  // R3
  a_r3_permit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !permit_s |-> (!tx_en && !key_en));

  // R4
  a_r4_tx_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (go && permit_s) |=> (tx_en || !permit_s));

  // R11
  a_r11_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !permit_s |=> (ms_cnt == '0));

  // R6
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt <= CNT_W'(DELAY_MS));

  // R6
  a_r6_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (ms_cnt >= $past(ms_cnt)));

  // R6
  a_r6_key_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    key_en |-> delay_done);

endmodule

bind trx_standby_seq trx_standby_chk #(.DELAY_MS(DELAY_MS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .key_en     (key_en),
  .go         (go),
  .permit_s   (permit_s),
  .delay_done (delay_done),
  .ms_cnt     (ms_cnt)
);

// File: tb/sim_trx_standby_seq.sv
module sim_trx_standby_seq;

  localparam int TPM = 2;
  localparam int DLY = 5;
  localparam int N   = TPM * DLY;

  // Stimulus vector: [7]sw_n [6]tuner [5]host [4]vox [3]permit [2]cw [1]key_n [0]brk
  localparam logic [7:0] IDLE = 8'b1000_1010;
  localparam logic [7:0] MAN  = 8'b0000_1010;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       tick_in;
  logic [7:0] drv;
  logic       tx_en, rx_en, key_en;

  int    checks = 0;
  int    fails  = 0;
  string tag;
  logic [7:0] h0, h1, h2;
  int    runt;
  bit    done_flag = 0;

  trx_standby_seq #(.SYNC_STAGES(2), .TICKS_PER_MS(TPM), .DELAY_MS(DLY)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_in),
    .stby_sw_n (drv[7]),
    .tuner_req (drv[6]),
    .host_req  (drv[5]),
    .vox_req   (drv[4]),
    .tx_permit (drv[3]),
    .cw_mode   (drv[2]),
    .cw_key_n  (drv[1]),
    .brk_full  (drv[0]),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .key_en    (key_en)
  );

  function automatic bit wants_tx(logic [7:0] v);
    bit any_src;
    any_src = (v[7] == 1'b0) || v[6] || v[5] || v[4];
    return any_src && v[3];
  endfunction

  function automatic bit keyer_ok(logic [7:0] v);
    if (v[2]) return (v[1] == 1'b0);
    return 1'b1;
  endfunction

  task automatic chk(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", t, $time, act, exp);
    end
  endtask

  // One negedge: compare against the model, then apply the next inputs.
  task automatic step(input logic [7:0] nv, input logic nt);
    bit g3, e_tx, e_key;
    @(negedge clk);
    g3   = wants_tx(h2);
    runt = g3 ? runt + (tick_in ? 1 : 0) : 0;
    e_tx  = g3 && h1[3];
    e_key = g3 && wants_tx(h1) && (runt >= N) && keyer_ok(h1);
    chk(tag, tx_en, e_tx);
    chk("R5", rx_en, !e_tx);
    chk(tag, key_en, e_key);
    h2 = h1; h1 = h0; h0 = nv;
    drv = nv; tick_in = nt;
  endtask

  task automatic hold(input logic [7:0] nv, input logic nt, input int n);
    for (int i = 0; i < n; i++) step(nv, nt);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; drv = MAN; tick_in = 1'b1;
    h0 = IDLE; h1 = IDLE; h2 = IDLE; runt = 0;
    repeat (3) @(negedge clk);
    // R12: reset state, even with a request applied
    chk("R12", tx_en, 1'b0);
    chk("R12", rx_en, 1'b1);
    chk("R12", key_en, 1'b0);
    drv = IDLE;
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";  hold(MAN, 1, N + 8);          hold(IDLE, 1, 6);
    tag = "R2";  hold(8'b1100_1010, 1, N + 6); hold(IDLE, 1, 6);
                 hold(8'b1010_1010, 1, N + 6); hold(IDLE, 1, 6);
                 hold(8'b1001_1010, 1, N + 6); hold(IDLE, 1, 6);
    tag = "R3";  hold(8'b0000_0010, 1, N + 6); hold(IDLE, 1, 6);
    tag = "R7";  hold(MAN, 0, N + 10);         hold(IDLE, 1, 6);
    tag = "R8";  hold(8'b0000_1110, 1, N + 5); hold(8'b0000_1100, 1, 5);
                 hold(8'b0000_1110, 1, 3);      hold(IDLE, 1, 6);
                 hold(8'b0000_1000, 1, N + 5); hold(IDLE, 1, 6);
    tag = "R9";  hold(8'b0000_1011, 1, N + 4); hold(MAN, 1, 4);
                 hold(8'b0000_1011, 1, 4);      hold(IDLE, 1, 6);
    tag = "R10"; hold(MAN, 1, N + 4);          hold(IDLE, 1, 5);
    tag = "R11"; hold(MAN, 1, N + 4);          hold(8'b0000_0010, 1, 3);
                 hold(MAN, 1, N + 4);          hold(IDLE, 1, 6);
    tag = "R6";  hold(MAN, 1, N - 2);          hold(IDLE, 1, 1);
                 hold(MAN, 1, N + 3);          hold(IDLE, 1, 6);

    tag = "R4";
    for (int b = 0; b < 400; b++) begin
      logic [7:0] v;
      logic       t;
      int         len;
      v    = 8'($urandom);
      v[3] = (($urandom % 6) != 0);
      if (($urandom % 3) == 0) v[7:4] = 4'b1000;
      t    = (($urandom % 8) != 0);
      len  = 1 + ($urandom % (2 * N + 5));
      hold(v, t, len);
    end
    hold(IDLE, 1, 6);

    done_flag = 1;
    summary();
  end

endmodule